// File: doc/BRIEF.md
# Four-Mode Barrel Shifter

This unit carries out the shift group of a small 32-bit load-store processor. The decoder hands it the operation code, the value read from the operand register, the low five bits of a second register, and the five-bit count slice of the instruction's modifier. It returns the word to be written back to the destination register. One shifter structure serves four forms: logical right, arithmetic right, logical left, and left rotate.

The shift distance normally comes from the instruction itself. When that count field is zero, the distance is taken from the low five bits of the second register instead. This lets a program shift by a value it computes at run time without needing a separate opcode.

The datapath is a logarithmic stage network with no state of its own. A parameter decides whether the result is captured in an output register, which adds one cycle of latency, or sent straight out. The output valid flag marks the cycles in which the result holds a new shift outcome.

Top module: `bshift_unit`

## Requirements
- R1: The 5-bit operation code selects the mode. 26 is logical right, 27 is arithmetic right, 28 is logical left and 29 is left rotate. These are the only codes treated as shifts.
- R2: The shift distance n is the count field when that field is nonzero. When the field is zero, n is the 5-bit register count input.
- R3: Logical right gives result bit i = operand bit i+n for i+n < 32. All other result bits are 0.
- R4: Arithmetic right fills the top n bits with operand bit 31 and keeps the rest as in R3. For example, shifting 0x97EAEC16 right arithmetically by 13 gives 0xFFFCBF57.
- R5: Logical left gives result bit i = operand bit i-n for i >= n. The low n bits are 0.
- R6: Rotate gives result bit i = operand bit (i-n) mod 32, so that operand bits 31..32-n land in the low n places.
- R7: With n = 0, which can only come from the register path, every mode returns the operand unchanged.
- R8: With the output register present, out_valid rises in the cycle after a valid shift input and the result appears in that same cycle. With no valid input, out_valid is low and the result holds its last value.
- R9: A valid input carrying any opcode other than 26..29 is ignored. out_valid stays low and the result keeps its previous value.
- R10: After reset, out_valid is 0 and result is 0.

Expressed as code, the distance rule is `n = (count_field != 0) ? count_field : reg_count`, and the rotate rule is `result = (operand << n) | (operand >> (32 - n))` for n in 1..31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operands and opcode are valid |
| op_code | input | 5 | Operation code |
| src_val | input | 32 | Value to be shifted |
| reg_cnt | input | 5 | Low bits of the count register |
| cnt_field | input | 5 | Count slice of the instruction modifier |
| out_valid | output | 1 | Result holds a new shift outcome |
| result | output | 32 | Shifted word for write-back |

## Verification
Two things can happen together in one cycle and must be judged together: choosing the shift distance between its two sources, and filling the vacated bits for the chosen mode. The bench provokes this with a zero count field and a nonzero register count on the arithmetic and rotate opcodes, and then with the same register count but a nonzero field. The second case must ignore the register count entirely. A behavioural bit-by-bit model in the bench predicts every cycle, including the held result after idle cycles and after non-shift opcodes, and the result is compared against it.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef enum logic [4:0] {
    OPC_SHR  = 5'd26,
    OPC_SHRA = 5'd27,
    OPC_SHL  = 5'd28,
    OPC_SHC  = 5'd29
  } shift_opc_e;

  typedef enum logic [1:0] {
    MODE_RLOG = 2'd0,
    MODE_RARI = 2'd1,
    MODE_LEFT = 2'd2,
    MODE_ROTL = 2'd3
  } shift_mode_e;

  // R1: recognise the four shift opcodes
  function automatic logic op_is_shift(input logic [4:0] op);
    return (op == OPC_SHR) || (op == OPC_SHRA) || (op == OPC_SHL) || (op == OPC_SHC);
  endfunction

  function automatic shift_mode_e op_mode(input logic [4:0] op);
    case (op)
      OPC_SHRA: return MODE_RARI;
      OPC_SHL:  return MODE_LEFT;
      OPC_SHC:  return MODE_ROTL;
      default:  return MODE_RLOG;
    endcase
  endfunction

endpackage

// File: rtl/bshift_amount.sv
module bshift_amount #(
  parameter int CW = 5
) (
  input  logic [CW-1:0] field_cnt,
  input  logic [CW-1:0] reg_cnt,
  output logic [CW-1:0] amount,
  output logic          from_reg
);
  // R2: zero field redirects to register count
  function automatic logic [CW-1:0] pick(input logic [CW-1:0] f, input logic [CW-1:0] r);
    return (f != '0) ? f : r;
  endfunction

  always_comb begin
    amount   = pick(field_cnt, reg_cnt);
    from_reg = (field_cnt == '0);
  end
endmodule

// File: rtl/bshift_core.sv
module bshift_core
  import bshift_pkg::*;
#(
  parameter int W = 32
) (
  input  shift_mode_e          mode,
  input  logic [W-1:0]         x,
  input  logic [$clog2(W)-1:0] amt,
  output logic [W-1:0]         y
);
  localparam int CW = $clog2(W);

  function automatic logic [W-1:0] stage_fn(input shift_mode_e m, input logic [W-1:0] v,
                                            input logic fill, input int s);
    logic [W-1:0] ones;
    ones = '1;
    case (m)
      MODE_RLOG: return v >> s;
      MODE_RARI: return (v >> s) | (fill ? ~(ones >> s) : '0);
      MODE_LEFT: return v << s;
      default:   return (v << s) | (v >> (W - s));
    endcase
  endfunction

  logic [W-1:0] st [0:CW];
  assign st[0] = x;

  for (genvar k = 0; k < CW; k++) begin : g_stage
    localparam int S = 1 << k;
    assign st[k+1] = amt[k] ? stage_fn(mode, st[k], x[W-1], S) : st[k];
  end

  assign y = st[CW];
endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
  import bshift_pkg::*;
#(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [4:0]           op_code,
  input  logic [W-1:0]         src_val,
  input  logic [$clog2(W)-1:0] reg_cnt,
  input  logic [$clog2(W)-1:0] cnt_field,
  output logic                 out_valid,
  output logic [W-1:0]         result
);
  localparam int CW = $clog2(W);

  logic          is_shift;
  logic          fire;
  shift_mode_e   mode;
  logic [CW-1:0] amt;
  logic          amt_from_reg;
  logic [W-1:0]  shifted;

  always_comb begin
    is_shift = op_is_shift(op_code);
    mode     = op_mode(op_code);
    fire     = in_valid && is_shift;
  end

  bshift_amount #(.CW(CW)) u_amt (
    .field_cnt (cnt_field),
    .reg_cnt   (reg_cnt),
    .amount    (amt),
    .from_reg  (amt_from_reg)
  );

  bshift_core #(.W(W)) u_core (
    .mode (mode),
    .x    (src_val),
    .amt  (amt),
    .y    (shifted)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        result    <= '0;
      end else begin
        out_valid <= fire;
        if (fire) result <= shifted;
      end
    end

    p_amt_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      amt_from_reg |-> (amt == reg_cnt));
    p_amt_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !amt_from_reg |-> (amt == cnt_field));
    p_rlog_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fire && mode == MODE_RLOG && amt != '0 |=> !result[W-1]);
    p_sign_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fire && mode == MODE_RARI |=> result[W-1] == $past(src_val[W-1]));
    p_left_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fire && mode == MODE_LEFT && amt != '0 |=> !result[0]);
    p_rot_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fire && mode == MODE_ROTL |=> $countones(result) == $countones($past(src_val)));
    p_zero_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fire && amt == '0 |=> result == $past(src_val));
    p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> out_valid);
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && $stable(result));
    p_nonshift_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !is_shift |=> !out_valid && $stable(result));
  end else begin : g_comb
    assign out_valid = fire;
    assign result    = shifted;
  end
endmodule

// File: tb/bshift_unit_tb.sv
module bshift_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic [31:0] src_val = '0;
  logic [4:0]  reg_cnt = '0;
  logic [4:0]  cnt_field = '0;
  logic        out_valid;
  logic [31:0] result;

  int n_cmp = 0;
  int n_bad = 0;

  logic        exp_valid = 1'b0;
  logic [31:0] exp_result = '0;
  string       exp_tag = "R10";

  always #2 clk = ~clk;

  bshift_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .src_val(src_val), .reg_cnt(reg_cnt), .cnt_field(cnt_field),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [31:0] model(input logic [4:0] op, input logic [31:0] a, input int n);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      case (op)
        5'd26: r[i] = (i + n < 32) ? a[i+n] : 1'b0;
        5'd27: r[i] = (i + n < 32) ? a[i+n] : a[31];
        5'd28: r[i] = (i >= n) ? a[i-n] : 1'b0;
        default: r[i] = a[(i - n + 32) % 32];
      endcase
    end
    return r;
  endfunction

  task automatic compare();
    n_cmp++;
    if (out_valid !== exp_valid || result !== exp_result) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b result=%08h, expected valid=%0b result=%08h",
               exp_tag, out_valid, result, exp_valid, exp_result);
    end
  endtask

  task automatic step(input logic v, input logic [4:0] op, input logic [31:0] a,
                      input logic [4:0] rc, input logic [4:0] fld, input string tag);
    @(negedge clk);
    compare();
    if (v && op >= 5'd26 && op <= 5'd29) begin
      exp_valid  = 1'b1;
      exp_result = model(op, a, (fld != 0) ? int'(fld) : int'(rc));
    end else begin
      exp_valid = 1'b0;
    end
    exp_tag   = tag;
    in_valid  = v;
    op_code   = op;
    src_val   = a;
    reg_cnt   = rc;
    cnt_field = fld;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got no finish, expected end of run");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    compare();
    // R4 worked example, R1 opcode map
    step(1, 5'd27, 32'h97EAEC16, 5'd0, 5'd13, "R4");
    step(1, 5'd26, 32'h97EAEC16, 5'd0, 5'd13, "R3");
    step(1, 5'd28, 32'h97EAEC16, 5'd0, 5'd13, "R5");
    step(1, 5'd29, 32'h97EAEC16, 5'd0, 5'd13, "R6");
    step(1, 5'd30, 32'h12345678, 5'd0, 5'd4, "R1");
    // R2: register path vs field path
    step(1, 5'd27, 32'h80000001, 5'd7, 5'd0, "R2");
    step(1, 5'd27, 32'h80000001, 5'd7, 5'd3, "R2");
    step(1, 5'd29, 32'hF000000F, 5'd9, 5'd0, "R2");
    step(1, 5'd29, 32'hF000000F, 5'd9, 5'd1, "R2");
    // R7: zero distance passes through
    step(1, 5'd26, 32'hDEADBEEF, 5'd0, 5'd0, "R7");
    step(1, 5'd27, 32'hCAFEF00D, 5'd0, 5'd0, "R7");
    step(1, 5'd28, 32'h0BADF00D, 5'd0, 5'd0, "R7");
    step(1, 5'd29, 32'h8000FFFF, 5'd0, 5'd0, "R7");
    // R8: idle holds, R9: non-shift ignored
    step(0, 5'd26, 32'hFFFFFFFF, 5'd0, 5'd1, "R8");
    step(1, 5'd12, 32'hFFFFFFFF, 5'd0, 5'd2, "R9");
    step(1, 5'd25, 32'h00000000, 5'd0, 5'd2, "R9");
    step(1, 5'd31, 32'h55555555, 5'd0, 5'd2, "R9");
    // distance 31 edges
    step(1, 5'd27, 32'h80000000, 5'd0, 5'd31, "R4");
    step(1, 5'd26, 32'h80000000, 5'd0, 5'd31, "R3");
    step(1, 5'd28, 32'h00000001, 5'd31, 5'd0, "R5");
    step(1, 5'd29, 32'h00000003, 5'd31, 5'd0, "R6");
    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      logic [4:0] rop;
      rop = 5'd26 + 5'($urandom_range(0, 4));
      step(1'($urandom_range(0, 3) != 0), rop, $urandom, 5'($urandom), 5'($urandom_range(0, 2) == 0 ? 0 : $urandom), "R1");
    end
    step(0, 5'd0, 32'h0, 5'd0, 5'd0, "R8");
    step(0, 5'd0, 32'h0, 5'd0, 5'd0, "R8");
    @(negedge clk);
    compare();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule